// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block takes one running clock and hands out a group of copies of it: single-ended outputs, true/complement output pairs, and one free-running output. An asynchronous, active-low stop request stops the gated copies. The request is first brought into the gated clock's own domain through a chain of rising-edge flops. The synchronized result is then applied together with a static enable bit for each output. That combined enable is taken on the falling edge, so a copy can only turn off or on while the clock is low.

A gated output therefore never shows a shortened high pulse. It either carries a whole high phase or stays low for that whole cycle. When stopped, a single-ended copy rests low. A pair rests with its true line low and its complement line high. The free-running copy ignores both the stop request and the enable bits. Clock generation and pad drivers belong to other blocks.

Top module: `clk_stop_gate`

## Requirements
- R1: `stop_n` passes through `SYNC_STAGES` rising-edge flops, default 2. A level applied in the low phase before rising edge k first governs the high pulse that starts at rising edge k+2. So after a stop request at most two more full high pulses leave the block, and after a release the first pulse comes at the same edge count.
- R2: A stopped single-ended output rests low, and it is low in every low phase of the clock.
- R3: Each high phase of a gated output is either a full high phase or absent. Its level is constant across the whole high phase, and the first pulse after a restart is full width.
- R4: Each pair output `pair_c_o[j]` is the inverse of `pair_t_o[j]`. A stopped or disabled pair therefore rests with true low and complement high.
- R5: `clk_free_o` follows `clk_i` in every cycle, regardless of `stop_n`, the enable bits and the state of the gated outputs.
- R6: Enable bit `se_en[i]` gates `se_clk_o[i]`, and bit `pair_en[j]` gates both lines of pair j. A bit value of 1 enables the output and 0 disables it. A disabled output behaves like a stopped one, and the other outputs keep running.
- R7: An enable bit changed in the low phase after rising edge k-1 first governs the high pulse at rising edge k+1. The change takes effect at a falling edge.
- R8: While `rst_n` is low, all gated outputs are stopped and the synchronizer holds the stop state. After release, gated pulses begin only once the R1 latency has elapsed.

Ports table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock being distributed and gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Asynchronous active-low stop request |
| se_en | input | N_SE | Per-output enable for single-ended copies, 1 enables |
| pair_en | input | N_PAIR | Per-pair enable for true/complement copies, 1 enables |
| clk_free_o | output | 1 | Free-running copy, never stopped |
| se_clk_o | output | N_SE | Gated single-ended copies |
| pair_t_o | output | N_PAIR | Gated true lines of the pairs |
| pair_c_o | output | N_PAIR | Gated complement lines of the pairs |

## Verification
The stop request is exercised in three ways: held long, released, and pulsed low for only one cycle. The long hold separates correct off latency from early or late stopping. The one-cycle pulse shows whether exactly one high pulse goes missing, which exposes a wrong synchronizer depth. The enable bits are toggled one at a time, both while the stop request is idle and in the same cycles as stop changes, which separates the single-cycle enable path from the two-stage stop path and reveals crossed bits between outputs. Each high phase is sampled near its start and near its end, and each low phase once, so a runt or a late turn-off shows as a mismatch.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;

  // Level of a gated copy: the clock passes only while its enable is held.
  function automatic logic gate_level(input logic clk, input logic en);
    return clk & en;
  endfunction

endpackage

// File: rtl/clk_req_sync.sv
`timescale 1ns/1ps
module clk_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic req_n,
  output logic run_o
);

  logic [STAGES-1:0] stg;

  if (STAGES > 1) begin : g_chain
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= {stg[STAGES-2:0], req_n};
    end
  end else begin : g_single
    always_ff @(posedge clk_i or negedge rst_n) begin
      if (!rst_n) stg <= '0;
      else        stg <= req_n;
    end
  end

  assign run_o = stg[STAGES-1];

endmodule

// File: rtl/clk_gate_cell.sv
`timescale 1ns/1ps
module clk_gate_cell
  import clk_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic run_i,
  input  logic cfg_en,
  output logic clk_o
);

  logic en_q;

  // Enable captured while the clock falls, so it only moves in the low phase.
  always_ff @(negedge clk_i or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= run_i & cfg_en;
  end

  assign clk_o = gate_level(clk_i, en_q);

  // R2
  stop_low_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
    !$past(run_i) |-> !clk_o);

  // R3
  full_pulse_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
    $past(run_i && cfg_en) |-> clk_o);

endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate #(
  parameter int N_SE        = 4,
  parameter int N_PAIR      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              stop_n,
  input  logic [N_SE-1:0]   se_en,
  input  logic [N_PAIR-1:0] pair_en,
  output logic              clk_free_o,
  output logic [N_SE-1:0]   se_clk_o,
  output logic [N_PAIR-1:0] pair_t_o,
  output logic [N_PAIR-1:0] pair_c_o
);

  localparam int N_GATED = N_SE + N_PAIR;

  logic               run_sync;
  logic [N_GATED-1:0] cfg_all;
  logic [N_GATED-1:0] gated;

  clk_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .req_n (stop_n),
    .run_o (run_sync)
  );

  assign cfg_all = {pair_en, se_en};

  for (genvar g = 0; g < N_GATED; g++) begin : g_cell
    clk_gate_cell u_cell (
      .clk_i  (clk_i),
      .rst_n  (rst_n),
      .run_i  (run_sync),
      .cfg_en (cfg_all[g]),
      .clk_o  (gated[g])
    );
  end

  assign se_clk_o   = gated[N_SE-1:0];
  assign pair_t_o   = gated[N_GATED-1:N_SE];
  assign pair_c_o   = ~pair_t_o;
  assign clk_free_o = clk_i;

  // R4
  diff_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pair_t_o == '0) && (pair_c_o == '1));

  // R5
  free_run_chk: assert property (@(negedge clk_i) disable iff (!rst_n)
    clk_free_o);

endmodule

// File: tb/clk_stop_gate_tb.sv
`timescale 1ns/1ps
module clk_stop_gate_tb;

  localparam int NS = 4;
  localparam int NP = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stop_n = 1'b1;
  logic [NS-1:0] se_en = '1;
  logic [NP-1:0] pair_en = '1;
  logic          clk_free_o;
  logic [NS-1:0] se_clk_o;
  logic [NP-1:0] pair_t_o;
  logic [NP-1:0] pair_c_o;

  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;
  logic prev_run = 1'b0;

  logic [NS-1:0] q_se[$];
  logic [NP-1:0] q_pt[$];
  string         q_tag[$];

  always #2 clk = ~clk;

  clk_stop_gate #(.N_SE(NS), .N_PAIR(NP), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_n(rst_n), .stop_n(stop_n), .se_en(se_en),
    .pair_en(pair_en), .clk_free_o(clk_free_o), .se_clk_o(se_clk_o),
    .pair_t_o(pair_t_o), .pair_c_o(pair_c_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Driver: one call per cycle, in the low phase. The stop level from the
  // previous call and the enables of this call decide the next high pulse.
  task automatic step(input logic s, input logic [NS-1:0] se,
                      input logic [NP-1:0] pr, input string tag);
    @(posedge clk);
    #3;
    stop_n  = s;
    se_en   = se;
    pair_en = pr;
    q_se.push_back(prev_run ? se : '0);
    q_pt.push_back(prev_run ? pr : '0);
    q_tag.push_back(tag);
    prev_run = s;
  endtask

  // Monitor: early and late in each high phase, then once in the low phase.
  initial begin
    forever begin
      @(posedge clk);
      if (armed && q_se.size() > 0) begin
        logic [NS-1:0] e_se;
        logic [NP-1:0] e_pt;
        string tg;
        e_se = q_se.pop_front();
        e_pt = q_pt.pop_front();
        tg   = q_tag.pop_front();
        #0.3;
        chk(se_clk_o == e_se, tg, "se early", 8'(se_clk_o), 8'(e_se));
        chk(pair_t_o == e_pt, tg, "pair_t early", 8'(pair_t_o), 8'(e_pt));
        chk(pair_c_o == ~e_pt, "R4", "pair_c high", 8'(pair_c_o), 8'(~e_pt));
        chk(clk_free_o == 1'b1, "R5", "free high", 8'(clk_free_o), 8'd1);
        #1.4;
        chk(se_clk_o == e_se, "R3", "se late", 8'(se_clk_o), 8'(e_se));
        chk(pair_t_o == e_pt, "R3", "pair_t late", 8'(pair_t_o), 8'(e_pt));
        #1.8;
        chk(se_clk_o == '0, "R2", "se low phase", 8'(se_clk_o), 8'd0);
        chk(pair_c_o == '1, "R4", "pair_c low phase", 8'(pair_c_o), 8'(2'b11));
        chk(clk_free_o == 1'b0, "R5", "free low", 8'(clk_free_o), 8'd0);
      end
    end
  end

  initial begin
    #80000;
    errors++;
    $display("FAIL R1 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: held in reset with stop idle and all enables on
    repeat (3) @(posedge clk);
    #1;
    chk(se_clk_o == '0, "R8", "se in reset", 8'(se_clk_o), 8'd0);
    chk(pair_t_o == '0, "R8", "pair_t in reset", 8'(pair_t_o), 8'd0);
    chk(pair_c_o == '1, "R8", "pair_c in reset", 8'(pair_c_o), 8'(2'b11));
    chk(clk_free_o == 1'b1, "R5", "free in reset", 8'(clk_free_o), 8'd1);
    @(posedge clk);
    #3;
    rst_n = 1'b1;
    q_se.push_back('0); q_pt.push_back('0); q_tag.push_back("R8");
    q_se.push_back('0); q_pt.push_back('0); q_tag.push_back("R8");
    prev_run = stop_n;
    armed = 1'b1;

    repeat (6) step(1'b1, 4'hF, 2'b11, "R8");
    // long stop, then release
    repeat (8) step(1'b0, 4'hF, 2'b11, "R1");
    repeat (6) step(1'b1, 4'hF, 2'b11, "R3");
    // single-cycle stop pulse drops exactly one high pulse
    step(1'b0, 4'hF, 2'b11, "R1");
    repeat (5) step(1'b1, 4'hF, 2'b11, "R1");
    // one enable at a time
    for (int i = 0; i < NS; i++) begin
      repeat (3) step(1'b1, 4'hF & ~(4'h1 << i), 2'b11, "R6");
      repeat (2) step(1'b1, 4'hF, 2'b11, "R7");
    end
    for (int j = 0; j < NP; j++) begin
      repeat (3) step(1'b1, 4'hF, 2'b11 & ~(2'b01 << j), "R4");
      repeat (2) step(1'b1, 4'hF, 2'b11, "R6");
    end
    // enables change in the same cycles as stop
    step(1'b0, 4'h5, 2'b01, "R7");
    step(1'b0, 4'hA, 2'b10, "R7");
    step(1'b1, 4'h3, 2'b11, "R7");
    step(1'b1, 4'hC, 2'b00, "R7");
    step(1'b0, 4'hF, 2'b11, "R1");
    step(1'b1, 4'h9, 2'b10, "R6");
    repeat (4) step(1'b1, 4'h6, 2'b01, "R6");
    repeat (4) step(1'b0, 4'h0, 2'b00, "R2");
    repeat (4) step(1'b1, 4'hF, 2'b11, "R3");
    wait (q_se.size() == 0);
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule